// File: doc/BRIEF.md
# Tiled SRAM bank wrapper

This block presents one logical single-port synchronous memory built from a grid of smaller physical banks. Rows of banks add depth and columns of banks add width. The upper address bits pick a bank row, and the lower address bits go unchanged to every bank. The write data is cut into column slices, and each slice is written under the control of the write-mask bit that covers it. Reads return data one cycle after the request. The read data comes from the bank row recorded in a row-select register, which loads only on an enabled read.

A column slice is as wide as the bank. The exception is a mask granule smaller than the bank that divides it evenly: then the slice is one granule wide and the upper bank bits stay unused. Each slice is therefore governed by a single mask bit, which the block folds into that bank's write enable. A parameter selects banks without a chip-enable input. In that case chip enable is folded into each bank's write and read enables.

Top module: `tiled_mem_wrap`

## Requirements
- R1: After reset the read data output is zero.
- R2: A read (ce=1, re=1, we=0) at address A returns, on the cycle after the request edge, the last data written to A. Address bits [3:0] index the bank and bits [5:4] pick the bank row (default 64 words of 14 bits, banks of 16 words).
- R3: The row-select register loads only when ce and re are both high. Otherwise it and the read data hold, even while the address and the other enables change.
- R4: A write occurs only when ce and we are both high. A write request with ce low leaves the memory unchanged, and at most one bank row is enabled in any cycle.
- R5: Mask bit g governs data bits [4g+3:4g], clipped to the data width. A granule whose mask bit is zero keeps its old contents.
- R6: The last column slice holds the leftover bits [13:12], under mask bit 3, and stores and returns them like any other slice.
- R7: With banks that lack a chip-enable input (BANK_HAS_CE=0), the wrapper behaves at its ports exactly as with chip-enabled banks.
- R8: Elaboration rejects two configurations: a logical depth that is not a multiple of the bank depth, and a mask granule that is not a power of two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Chip enable |
| re | input | 1 | Read enable |
| we | input | 1 | Write enable |
| addr | input | 6 | Word address |
| wdata | input | 14 | Write data |
| wmask | input | 4 | Per-granule write mask, one bit per 4 data bits |
| rdata | output | 14 | Read data, valid the cycle after a read |

## Verification
A write lands at the clock edge on which it is presented. A read's data and the row select both update at the request edge, so each result is due one cycle after its stimulus. The bench drives every request on a falling edge and samples on the following falling edge, half a cycle after the edge that produced the result. The hold checks sample rdata on each of several idle or non-reading cycles after a read and expect it to stay unchanged.

// File: rtl/tmw_pkg.sv
// Shared sizing helpers for the tiled memory wrapper.
package tmw_pkg;

    // Width of one column slice: one mask granule when the granule evenly
    // divides a wider bank, otherwise the full bank width.
    function automatic int slice_width(input int bank_w, input int gran);
        if (gran < bank_w && (bank_w % gran) == 0)
            return gran;
        return bank_w;
    endfunction

    // Number of column slices needed to cover the data width.
    function automatic int col_count(input int data_w, input int slice_w);
        return (data_w + slice_w - 1) / slice_w;
    endfunction

endpackage

// File: rtl/tmw_bank.sv
// Physical bank model: synchronous single-port array with one cycle of read
// latency. Assumes active-high enables; a write wins over a read in the same
// cycle. Only the output register is reset.
module tmw_bank #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Store write data when enabled.
    always_ff @(posedge clk) begin
        if (ce && we)
            mem[addr] <= wdata;
    end

    // Capture read data on an enabled read that is not a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (ce && re && !we)
            rdata <= mem[addr];
    end
endmodule

// File: rtl/tmw_row.sv
// One row of banks covering the full data width. Splits write data into
// column slices, gives each slice the mask bit of the granule it starts in,
// and joins the slices' read data with the lowest slice in the lowest bits.
// Assumes ce/we/re arrive already qualified by this row's address match.
module tmw_row #(
    parameter int DATA_W      = 14,
    parameter int BANK_W      = 8,
    parameter int BANK_DEPTH  = 16,
    parameter int SLICE_W     = 4,
    parameter int NUM_COLS    = 4,
    parameter int GRAN        = 4,
    parameter int MASK_W      = 4,
    parameter int BANK_HAS_CE = 1,
    parameter int BANK_AW     = $clog2(BANK_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ce,
    input  logic               we,
    input  logic               re,
    input  logic [BANK_AW-1:0] addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [MASK_W-1:0]  wmask,
    output logic [DATA_W-1:0]  rdata
);
    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        localparam int LO = c * SLICE_W;
        localparam int SW = (c == NUM_COLS - 1) ? DATA_W - LO : SLICE_W;

        logic              bk_ce, bk_we, bk_re;
        logic [BANK_W-1:0] bk_wd, bk_rd;

        // Zero-extend this slice of write data to the bank width.
        assign bk_wd = BANK_W'(wdata[LO +: SW]);

        if (BANK_HAS_CE != 0) begin : g_ce
            // Bank gates itself with chip enable.
            assign bk_ce = ce;
            assign bk_we = we & wmask[LO / GRAN];
            assign bk_re = re;
        end else begin : g_fold
            // Bank lacks chip enable: fold it into write and read enables.
            assign bk_ce = 1'b1;
            assign bk_we = we & ce & wmask[LO / GRAN];
            assign bk_re = re & ce;
        end

        tmw_bank #(.W(BANK_W), .DEPTH(BANK_DEPTH)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .ce    (bk_ce),
            .we    (bk_we),
            .re    (bk_re),
            .addr  (addr),
            .wdata (bk_wd),
            .rdata (bk_rd)
        );

        // Place the used bank bits at this slice's position.
        assign rdata[LO +: SW] = bk_rd[SW-1:0];

        if (SW < BANK_W) begin : g_pad
            logic unused_hi;
            assign unused_hi = ^bk_rd[BANK_W-1:SW];
        end
    end
endmodule

// File: rtl/tiled_mem_wrap.sv
// Logical single-port memory built from a grid of tmw_bank instances.
// Decodes the bank row from the upper address bits and gates each row's
// enables. It steers read data through a row select that loads only on
// enabled reads. Assumes DEPTH is a multiple of BANK_DEPTH, GRAN is a
// power of two, and each slice falls within a single mask granule.
module tiled_mem_wrap
    import tmw_pkg::*;
#(
    parameter int DATA_W      = 14,
    parameter int DEPTH       = 64,
    parameter int BANK_W      = 8,
    parameter int BANK_DEPTH  = 16,
    parameter int GRAN        = 4,
    parameter int BANK_HAS_CE = 1,
    parameter int AW          = $clog2(DEPTH),
    parameter int MASK_W      = (DATA_W + GRAN - 1) / GRAN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              re,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [MASK_W-1:0] wmask,
    output logic [DATA_W-1:0] rdata
);
    localparam int BANK_AW  = $clog2(BANK_DEPTH);
    localparam int ROWS     = DEPTH / BANK_DEPTH;
    localparam int ROW_AW   = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int SLICE_W  = slice_width(BANK_W, GRAN);
    localparam int NUM_COLS = col_count(DATA_W, SLICE_W);

    // Elaboration-time configuration checks (R8).
    if (DEPTH % BANK_DEPTH != 0) begin : g_bad_depth
        $error("logical depth must be a multiple of the bank depth");
    end
    if ((GRAN & (GRAN - 1)) != 0) begin : g_bad_gran
        $error("mask granule must be a power of two");
    end
    if (GRAN % SLICE_W != 0) begin : g_bad_slice
        $error("each slice must fall within one mask granule");
    end

    logic [ROW_AW-1:0] addr_hi;
    logic [ROW_AW-1:0] rsel_q;
    logic [ROWS-1:0]   row_ce;
    logic [DATA_W-1:0] row_rd [ROWS];

    if (ROWS > 1) begin : g_rowaddr
        // Row index comes from the address bits above the bank index.
        assign addr_hi = addr[AW-1:BANK_AW];
    end else begin : g_onerow
        assign addr_hi = '0;
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic hit;
        // Row address match gating all of this row's enables.
        assign hit       = (addr_hi == ROW_AW'(r));
        assign row_ce[r] = ce & hit;

        tmw_row #(
            .DATA_W      (DATA_W),
            .BANK_W      (BANK_W),
            .BANK_DEPTH  (BANK_DEPTH),
            .SLICE_W     (SLICE_W),
            .NUM_COLS    (NUM_COLS),
            .GRAN        (GRAN),
            .MASK_W      (MASK_W),
            .BANK_HAS_CE (BANK_HAS_CE)
        ) u_row (
            .clk   (clk),
            .rst_n (rst_n),
            .ce    (row_ce[r]),
            .we    (we & hit),
            .re    (re & hit),
            .addr  (addr[BANK_AW-1:0]),
            .wdata (wdata),
            .wmask (wmask),
            .rdata (row_rd[r])
        );
    end

    // Remember which row was read, so the output mux matches bank latency.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rsel_q <= '0;
        else if (ce && re)
            rsel_q <= addr_hi;
    end

    // Forward the selected row's data, zero when no row matches.
    always_comb begin
        rdata = '0;
        for (int r = 0; r < ROWS; r++)
            if (rsel_q == ROW_AW'(r))
                rdata = row_rd[r];
    end
endmodule

// File: rtl/tmw_checker.sv
// Protocol checker for tiled_mem_wrap: row enable decoding and the
// behaviour of the registered row select. Attached by bind below.
module tmw_checker #(
    parameter int AW      = 6,
    parameter int BANK_AW = 4,
    parameter int ROWS    = 4,
    parameter int ROW_AW  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce,
    input logic              re,
    input logic [AW-1:0]     addr,
    input logic [ROWS-1:0]   row_ce,
    input logic [ROW_AW-1:0] rsel
);
    AST_ROW_CE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_ce)); // R4
    AST_ROW_CE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |-> (row_ce == '0)); // R4
    AST_ROW_CE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ce |-> ($countones(row_ce) == 1)); // R2
    AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && re) |=> (rsel == ROW_AW'($past(addr) >> BANK_AW))); // R3
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(ce && re) |=> $stable(rsel)); // R3
    AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(rsel) < ROWS)); // R3
endmodule

bind tiled_mem_wrap tmw_checker #(
    .AW      (AW),
    .BANK_AW (BANK_AW),
    .ROWS    (ROWS),
    .ROW_AW  (ROW_AW)
) u_tmw_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce     (ce),
    .re     (re),
    .addr   (addr),
    .row_ce (row_ce),
    .rsel   (rsel_q)
);

// File: tb/test_tiled_mem_wrap.sv
`timescale 1ns/1ps
module test_tiled_mem_wrap;
    localparam int DW = 14;
    localparam int DEP = 64;
    localparam int AWB = 6;
    localparam int MW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce = 1'b0, re = 1'b0, we = 1'b0;
    logic [AWB-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [MW-1:0] wmask = '0;
    logic [DW-1:0] rdata, rdata_nce;
    logic [DW-1:0] ref_mem [DEP];
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tiled_mem_wrap i_tiled_mem_wrap (
        .clk(clk), .rst_n(rst_n), .ce(ce), .re(re), .we(we),
        .addr(addr), .wdata(wdata), .wmask(wmask), .rdata(rdata));

    tiled_mem_wrap #(.BANK_HAS_CE(0)) i_tiled_mem_wrap_nce (
        .clk(clk), .rst_n(rst_n), .ce(ce), .re(re), .we(we),
        .addr(addr), .wdata(wdata), .wmask(wmask), .rdata(rdata_nce));

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply one write request for a cycle; the reference follows if ce_v and we.
    task automatic wr(input logic [AWB-1:0] a, input logic [DW-1:0] d,
                      input logic [MW-1:0] m, input logic ce_v);
        @(negedge clk);
        ce = ce_v; we = 1'b1; re = 1'b0; addr = a; wdata = d; wmask = m;
        @(posedge clk);
        @(negedge clk);
        ce = 1'b0; we = 1'b0;
        if (ce_v)
            for (int b = 0; b < DW; b++)
                if (m[b / 4]) ref_mem[a][b] = d[b];
    endtask

    // Issue a read; return with rdata due (one edge later, sampled at negedge).
    task automatic rd(input logic [AWB-1:0] a);
        @(negedge clk);
        ce = 1'b1; re = 1'b1; we = 1'b0; addr = a;
        @(posedge clk);
        @(negedge clk);
        ce = 1'b0; re = 1'b0;
        #0.5;
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int k);
        return DW'((a * 1109 + k * 397 + 321) % 16384);
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [DW-1:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        chk("R1 reset rdata", rdata, '0);
        chk("R1 reset rdata no-ce banks", rdata_nce, '0);

        // R2/R7: full-mask fill of every address, read back all rows and columns
        for (int a = 0; a < DEP; a++) wr(AWB'(a), pat(a, 0), 4'hF, 1'b1);
        for (int a = 0; a < DEP; a++) begin
            rd(AWB'(a));
            chk("R2 full write readback", rdata, ref_mem[a]);
            chk("R7 no-ce banks readback", rdata_nce, ref_mem[a]);
        end

        // R5: masked overwrite with all 16 mask patterns
        for (int a = 0; a < DEP; a++) wr(AWB'(a), pat(a, 5), MW'(a % 16), 1'b1);
        for (int a = 0; a < DEP; a++) begin
            rd(AWB'(a));
            chk("R5 masked readback", rdata, ref_mem[a]);
            chk("R7 masked no-ce banks", rdata_nce, ref_mem[a]);
        end

        // R6: leftover top slice under mask bit 3 only
        wr(6'd63, 14'h3FFF, 4'b1000, 1'b1);
        rd(6'd63);
        chk("R6 top slice bits", rdata, ref_mem[63]);
        chk("R6 top slice value", rdata[13:12], 2'b11);

        // R4: write request with ce low is ignored
        wr(6'd5, ~ref_mem[5], 4'hF, 1'b0);
        rd(6'd5);
        chk("R4 ce-low write ignored", rdata, ref_mem[5]);
        chk("R4 ce-low write ignored no-ce banks", rdata_nce, ref_mem[5]);

        // R3: read data holds while no enabled read occurs
        rd(6'd17);
        held = ref_mem[17];
        chk("R3 hold initial read", rdata, held);
        @(negedge clk);
        ce = 1'b1; re = 1'b0; addr = 6'd40;
        @(negedge clk);
        #0.5;
        chk("R3 hold ce without re", rdata, held);
        chk("R3 hold ce without re no-ce banks", rdata_nce, held);
        @(negedge clk);
        ce = 1'b0; re = 1'b1; addr = 6'd50;
        @(negedge clk);
        #0.5;
        chk("R3 hold re without ce", rdata, held);
        chk("R3 hold re without ce no-ce banks", rdata_nce, held);
        re = 1'b0;
        wr(6'd1, 14'h1234, 4'hF, 1'b1);
        #0.5;
        chk("R3 hold across other-row write", rdata, held);
        wr(6'd17, 14'h2AAA, 4'hF, 1'b1);
        #0.5;
        chk("R3 hold across same-row write", rdata, held);
        rd(6'd17);
        chk("R3 new read after hold", rdata, 14'h2AAA);
        rd(6'd1);
        chk("R2 row 0 after write", rdata, 14'h1234);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule